// File: doc/BRIEF.md
# Pipelined Control Signal Generator

This block turns the opcode of the instruction sitting in the decode stage of a five-stage in-order pipeline into the control signals the datapath needs. It does not run a central state machine. Each instruction's control word is decoded once and then travels down the pipeline registers alongside the instruction. At each boundary the groups that are no longer needed are dropped, so every later stage sees only its own group: execute, memory or writeback.

The decode-to-execute register takes all three groups. The execute-to-memory register keeps only the memory and writeback groups. The memory-to-writeback register keeps only the writeback group. A bubble request or a flush request loads an all-zero word into the affected register, and all zeros means no operation. The datapath uses the bubble input for load-use stalls and the three flush inputs to squash wrong-path instructions. Don't-care fields in the decode table resolve to zero.

Top module: `pipe_ctrl_gen`

## Requirements
- R1: While rst_n is low every control output reads 0. The reset takes effect asynchronously and is released through a two-flop synchronizer.
- R2: Opcode 6'b000000 (register-register) yields ex_dst_sel=1, ex_alu_mode=2'b10, ex_imm_sel=0, mem_branch=0, mem_read=0, mem_write=0, wb_reg_we=1, wb_load_sel=0.
- R3: Opcode 6'b100011 (load) yields ex_dst_sel=0, ex_alu_mode=2'b00, ex_imm_sel=1, mem_read=1, mem_branch=0, mem_write=0, wb_reg_we=1, wb_load_sel=1. The memory read and write outputs are never both 1.
- R4: Opcode 6'b101011 (store) yields ex_imm_sel=1, ex_alu_mode=2'b00, mem_write=1. Every other output is 0.
- R5: Opcode 6'b000100 (branch if equal) yields ex_alu_mode=2'b01, mem_branch=1. Every other output is 0.
- R6: Any other opcode yields all control outputs 0.
- R7: When bubble_i is 1, all-zero control enters the decode-to-execute register, whatever the opcode.
- R8: An opcode sampled at clock edge k shows its execute group after edge k, its memory group after edge k+1 and its writeback group after edge k+2.
- R9: When flush_idex_i is 1 at an edge, the decode-to-execute register loads zeros.
- R10: When flush_exmem_i is 1 at an edge, the execute-to-memory register loads zeros instead of the memory and writeback groups leaving the decode-to-execute register.
- R11: When flush_memwb_i is 1 at an edge, the memory-to-writeback register loads zeros instead of the writeback group leaving the execute-to-memory register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode of the instruction in decode |
| bubble_i | input | 1 | Insert a no-op into the execute stage |
| flush_idex_i | input | 1 | Clear the decode-to-execute register |
| flush_exmem_i | input | 1 | Clear the execute-to-memory register |
| flush_memwb_i | input | 1 | Clear the memory-to-writeback register |
| ex_dst_sel_o | output | 1 | Destination register select (1 = rd field) |
| ex_alu_mode_o | output | 2 | ALU operation class for the ALU decoder |
| ex_imm_sel_o | output | 1 | ALU second operand is the immediate |
| mem_branch_o | output | 1 | Instruction is a conditional branch |
| mem_read_o | output | 1 | Data memory read |
| mem_write_o | output | 1 | Data memory write |
| wb_reg_we_o | output | 1 | Register file write enable |
| wb_load_sel_o | output | 1 | Write back memory data instead of the ALU result |

## Verification
Assertions check on every cycle that the memory group leaving the execute-to-memory register and the writeback group leaving the memory-to-writeback register match what the previous register held one cycle earlier, unless a flush was asserted. They also check that a bubble or a decode-stage flush produces zero execute controls, that memory read and write are never both active, and that reset holds every output at zero. The exact decode values for each opcode class come only from the bench's scenarios. So do the sweep over all opcodes for the zero default, and interleaved flushes at different depths with their effect on specific instructions.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

  typedef struct packed {
    logic       dst_sel;
    logic [1:0] alu_mode;
    logic       imm_sel;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic rd;
    logic wr;
  } mem_ctl_t;

  typedef struct packed {
    logic reg_we;
    logic load_sel;
  } wb_ctl_t;

  typedef struct packed {
    ex_ctl_t  ex;
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } idex_t;

  typedef struct packed {
    mem_ctl_t mem;
    wb_ctl_t  wb;
  } exmem_t;

endpackage

// File: rtl/pipe_ctrl_rst_sync.sv
module pipe_ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pipe_ctrl_decode.sv
module pipe_ctrl_decode
  import pipe_ctrl_pkg::*;
#(
  parameter int               OPC_W    = 6,
  parameter logic [OPC_W-1:0] OPC_REG  = 6'b000000,
  parameter logic [OPC_W-1:0] OPC_LOAD = 6'b100011,
  parameter logic [OPC_W-1:0] OPC_STOR = 6'b101011,
  parameter logic [OPC_W-1:0] OPC_BEQ  = 6'b000100
) (
  input  logic [OPC_W-1:0] opcode,
  output idex_t            ctl
);
  always_comb begin
    ctl = '0;
    unique case (opcode)
      OPC_REG: begin
        ctl.ex.dst_sel  = 1'b1;
        ctl.ex.alu_mode = 2'b10;
        ctl.wb.reg_we   = 1'b1;
      end
      OPC_LOAD: begin
        ctl.ex.imm_sel  = 1'b1;
        ctl.mem.rd      = 1'b1;
        ctl.wb.reg_we   = 1'b1;
        ctl.wb.load_sel = 1'b1;
      end
      OPC_STOR: begin
        ctl.ex.imm_sel  = 1'b1;
        ctl.mem.wr      = 1'b1;
      end
      OPC_BEQ: begin
        ctl.ex.alu_mode = 2'b01;
        ctl.mem.branch  = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/pipe_ctrl_stage_reg.sv
module pipe_ctrl_stage_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = clr ? '0 : d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/pipe_ctrl_gen.sv
module pipe_ctrl_gen
  import pipe_ctrl_pkg::*;
#(
  parameter int OPC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  input  logic             bubble_i,
  input  logic             flush_idex_i,
  input  logic             flush_exmem_i,
  input  logic             flush_memwb_i,
  output logic             ex_dst_sel_o,
  output logic [1:0]       ex_alu_mode_o,
  output logic             ex_imm_sel_o,
  output logic             mem_branch_o,
  output logic             mem_read_o,
  output logic             mem_write_o,
  output logic             wb_reg_we_o,
  output logic             wb_load_sel_o
);
  localparam int IDEX_W  = $bits(idex_t);
  localparam int EXMEM_W = $bits(exmem_t);
  localparam int MEMWB_W = $bits(wb_ctl_t);

  logic    rst_sn;
  idex_t   dec_ctl;
  idex_t   idex_d, idex_q;
  exmem_t  exmem_d, exmem_q;
  wb_ctl_t memwb_d, memwb_q;

  pipe_ctrl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sn)
  );

  pipe_ctrl_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode(opcode_i), .ctl(dec_ctl)
  );

  // bubble selects the no-op word before the decode-to-execute register
  always_comb idex_d = bubble_i ? '0 : dec_ctl;

  pipe_ctrl_stage_reg #(.W(IDEX_W)) u_idex (
    .clk(clk), .rst_n(rst_sn), .clr(flush_idex_i), .d(idex_d), .q(idex_q)
  );

  // execute group is consumed here; memory and writeback move on
  always_comb begin
    exmem_d.mem = idex_q.mem;
    exmem_d.wb  = idex_q.wb;
  end

  pipe_ctrl_stage_reg #(.W(EXMEM_W)) u_exmem (
    .clk(clk), .rst_n(rst_sn), .clr(flush_exmem_i), .d(exmem_d), .q(exmem_q)
  );

  // memory group is consumed here; only writeback moves on
  always_comb memwb_d = exmem_q.wb;

  pipe_ctrl_stage_reg #(.W(MEMWB_W)) u_memwb (
    .clk(clk), .rst_n(rst_sn), .clr(flush_memwb_i), .d(memwb_d), .q(memwb_q)
  );

  assign ex_dst_sel_o  = idex_q.ex.dst_sel;
  assign ex_alu_mode_o = idex_q.ex.alu_mode;
  assign ex_imm_sel_o  = idex_q.ex.imm_sel;
  assign mem_branch_o  = exmem_q.mem.branch;
  assign mem_read_o    = exmem_q.mem.rd;
  assign mem_write_o   = exmem_q.mem.wr;
  assign wb_reg_we_o   = memwb_q.reg_we;
  assign wb_load_sel_o = memwb_q.load_sel;

  // R1: reset holds every output at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_sn |-> ({ex_dst_sel_o, ex_alu_mode_o, ex_imm_sel_o, mem_branch_o,
                  mem_read_o, mem_write_o, wb_reg_we_o, wb_load_sel_o} == '0));

  // R3: read and write of data memory are exclusive
  a_r3_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_sn)
    !(mem_read_o && mem_write_o));

  // R7: bubble gives zero execute controls and no-op downstream groups
  a_r7_bubble_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    bubble_i |=> (idex_q == '0));

  // R9: decode-stage flush clears the decode-to-execute register
  a_r9_flush_idex: assert property (@(posedge clk) disable iff (!rst_sn)
    flush_idex_i |=> ({ex_dst_sel_o, ex_alu_mode_o, ex_imm_sel_o} == '0));

  // R8, R10: memory group follows the previous register unless flushed
  a_r10_exmem_follow: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> (exmem_q == ($past(flush_exmem_i) ? '0 :
                       {$past(idex_q.mem), $past(idex_q.wb)})));

  // R8, R11: writeback group follows the previous register unless flushed
  a_r11_memwb_follow: assert property (@(posedge clk) disable iff (!rst_sn)
    $past(rst_sn) |-> (memwb_q == ($past(flush_memwb_i) ? '0 :
                       $past(exmem_q.wb))));
endmodule

// File: tb/pipe_ctrl_gen_bench.sv
`timescale 1ns/1ps
module pipe_ctrl_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] opcode_i;
  logic       bubble_i, flush_idex_i, flush_exmem_i, flush_memwb_i;
  logic       ex_dst_sel_o, ex_imm_sel_o;
  logic [1:0] ex_alu_mode_o;
  logic       mem_branch_o, mem_read_o, mem_write_o;
  logic       wb_reg_we_o, wb_load_sel_o;

  int errors = 0;
  int checks = 0;
  bit mon_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pipe_ctrl_gen u_pipe_ctrl_gen (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .bubble_i(bubble_i),
    .flush_idex_i(flush_idex_i), .flush_exmem_i(flush_exmem_i),
    .flush_memwb_i(flush_memwb_i), .ex_dst_sel_o(ex_dst_sel_o),
    .ex_alu_mode_o(ex_alu_mode_o), .ex_imm_sel_o(ex_imm_sel_o),
    .mem_branch_o(mem_branch_o), .mem_read_o(mem_read_o),
    .mem_write_o(mem_write_o), .wb_reg_we_o(wb_reg_we_o),
    .wb_load_sel_o(wb_load_sel_o)
  );

  // scoreboard queues: expected {ex[3:0], mem[2:0], wb[1:0]}
  logic [8:0] q_exp[$];
  bit         q_fx[$];
  bit         q_fm[$];
  string      q_tag[$];

  function automatic logic [8:0] expect_of(logic [5:0] opc);
    case (opc)
      6'b000000: return {4'b1100, 3'b000, 2'b10};  // R2
      6'b100011: return {4'b0001, 3'b010, 2'b11};  // R3
      6'b101011: return {4'b0001, 3'b001, 2'b00};  // R4
      6'b000100: return {4'b0010, 3'b100, 2'b00};  // R5
      default:   return 9'b0;                      // R6
    endcase
  endfunction

  function automatic string tag_of(logic [5:0] opc);
    case (opc)
      6'b000000: return "R2";
      6'b100011: return "R3";
      6'b101011: return "R4";
      6'b000100: return "R5";
      default:   return "R6";
    endcase
  endfunction

  task automatic drive(input logic [5:0] opc, input bit bub, input bit fi,
                       input bit fx, input bit fm, input string tag);
    @(negedge clk);
    opcode_i      = opc;
    bubble_i      = bub;
    flush_idex_i  = fi;
    flush_exmem_i = fx;
    flush_memwb_i = fm;
    q_exp.push_back((bub || fi) ? 9'b0 : expect_of(opc));
    q_fx.push_back(fx);
    q_fm.push_back(fm);
    q_tag.push_back(tag);
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: reference stage model fed from the queue
  logic [8:0] s1 = '0;
  logic [4:0] s2 = '0;
  logic [1:0] s3 = '0;
  string t1 = "R8", t2 = "R8", t3 = "R8";
  always @(posedge clk) begin
    #5;
    if (mon_on) begin
      logic [8:0] it;
      bit fx, fm;
      string tg;
      if (q_exp.size() > 0) begin
        it = q_exp.pop_front(); fx = q_fx.pop_front();
        fm = q_fm.pop_front();  tg = q_tag.pop_front();
      end else begin
        it = '0; fx = 1'b0; fm = 1'b0; tg = "R7";
      end
      s3 = fm ? 2'b00 : s2[1:0];
      t3 = fm ? "R11" : t2;
      s2 = fx ? 5'b0 : s1[4:0];
      t2 = fx ? "R10" : t1;
      s1 = it;
      t1 = tg;
      check({t1, " ex"}, {ex_dst_sel_o, ex_alu_mode_o, ex_imm_sel_o}, s1[8:5]);
      check({t2, "/R8 mem"}, {1'b0, mem_branch_o, mem_read_o, mem_write_o}, {1'b0, s2[4:2]});
      check({t3, "/R8 wb"}, {2'b0, wb_reg_we_o, wb_load_sel_o}, {2'b0, s3});
    end
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    opcode_i = 6'b000000; bubble_i = 1'b0;
    flush_idex_i = 1'b0; flush_exmem_i = 1'b0; flush_memwb_i = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: register-register opcode presented during reset must not appear
    check("R1 ex",  {ex_dst_sel_o, ex_alu_mode_o, ex_imm_sel_o}, 4'b0);
    check("R1 mem", {1'b0, mem_branch_o, mem_read_o, mem_write_o}, 4'b0);
    check("R1 wb",  {2'b0, wb_reg_we_o, wb_load_sel_o}, 4'b0);
    bubble_i = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R2..R5, R8: one of each class, back to back
    drive(6'b000000, 0, 0, 0, 0, "R2");
    drive(6'b100011, 0, 0, 0, 0, "R3");
    drive(6'b101011, 0, 0, 0, 0, "R4");
    drive(6'b000100, 0, 0, 0, 0, "R5");
    drive(6'b111111, 0, 0, 0, 0, "R6");
    // R7: bubble over a load and a register op
    drive(6'b100011, 1, 0, 0, 0, "R7");
    drive(6'b000000, 1, 0, 0, 0, "R7");
    drive(6'b100011, 0, 0, 0, 0, "R3");
    // R9: decode flush
    drive(6'b000000, 0, 1, 0, 0, "R9");
    drive(6'b101011, 0, 0, 0, 0, "R4");
    // R10: flush execute-to-memory (squashes the store just above)
    drive(6'b100011, 0, 0, 1, 0, "R3");
    drive(6'b000000, 0, 0, 0, 0, "R2");
    // R11: flush memory-to-writeback (squashes the load)
    drive(6'b000100, 0, 0, 0, 1, "R5");
    drive(6'b000000, 0, 0, 1, 1, "R2");
    drive(6'b100011, 0, 1, 1, 0, "R9");
    // R6 and all classes: sweep every opcode
    for (int i = 0; i < 64; i++) begin
      logic [5:0] o;
      o = 6'(i);
      drive(o, 0, 0, 0, 0, tag_of(o));
    end
    // drain
    repeat (4) drive(6'b111111, 1, 0, 0, 0, "R7");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule